// File: doc/BRIEF.md
# Command-Table Register Initialization Sequencer

The sequencer brings a group of hardware registers to a known state by walking a table of encoded commands. Given a start index and an exclusive end index into an external command memory, it fetches one command at a time and turns it into register-bus transactions on a master port: single writes, reads whose result is thrown away, incrementing bursts copied from an external data memory, zero fills, and fills that repeat a 64-bit pattern. Two conditional commands compare a mode-flag word against a mask and can jump over a following run of commands, so one table can serve several configurations.

Both memories are read through synchronous ports: the address presented in one cycle returns data in the next. The register bus is a valid/ready master. Once `bus_valid` is raised, `bus_write`, `bus_addr`, `bus_wdata` and `bus_last` hold their values until a cycle in which `bus_ready` is high. The transfer completes in that cycle, and the next transaction appears no earlier than the cycle after. The slave may hold `bus_ready` low for as long as it needs without any loss. Each command word is 60 bits: opcode in bits 59:56, byte address in 55:32, and a 32-bit operand whose upper half (31:16) is a length or mask and whose lower half (15:0) is an immediate low half, a data-memory offset, or a skip count.

Top module: `initseq_top`

## Requirements
- R1: When `start` is seen while idle and `first_idx` is greater than or equal to `last_idx`, `done` rises in the following cycle and no bus transaction is issued.
- R2: Commands run in ascending index order from `first_idx` up to, but not including, `last_idx`; every transaction of one command completes before the next command is fetched.
- R3: Opcode 0 issues one transaction with `bus_write`=0 to the command address, with `bus_last`=1; the slave's answer is not used.
- R4: Opcode 1 issues one write of the full 32-bit operand to the command address, with `bus_last`=1.
- R5: Opcode 2 writes L words (L = operand bits 31:16), word k taken from data address (offset + k) and sent to byte address + 4k. `bus_last` is set on the final word only, and L = 0 issues nothing.
- R6: Opcode 3 writes zero to L consecutive words (byte address + 4k). `bus_last` marks the end of each chunk of CHUNK_WORDS words (default 8) and the final word.
- R7: Opcode 4 reads a pattern from data words offset (low half) and offset+1 (high half), then writes 2L words. Even words carry the low half, odd words carry the high half, and `bus_last` uses the same chunking as R6.
- R8: Opcode 5: if (mode_flags & mask) differs from mask, the next index is current + 1 + skip; otherwise current + 1. Mask is operand bits 31:16 and skip is bits 15:0.
- R9: Opcode 6: if (mode_flags & mask) is zero, the next index is current + 1 + skip; otherwise current + 1. A jump to or beyond `last_idx` ends the run without error.
- R10: Opcodes 7 to 15 set `err`, issue nothing further, and end the run. `err` stays high until the next accepted `start`, which clears it.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid` and all bus fields stay unchanged in the next cycle.
- R12: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a single-cycle pulse at the end of every run, whether it completes or aborts, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when idle |
| first_idx | input | IDX_W | First command index of the run |
| last_idx | input | IDX_W | Exclusive end index of the run |
| mode_flags | input | 16 | Mode bits tested by conditional commands |
| cmd_raddr | output | IDX_W | Command memory read address |
| cmd_rdata | input | 60 | Command word, one cycle after its address |
| dat_raddr | output | DAT_AW | Data memory read address |
| dat_rdata | input | 32 | Data word, one cycle after its address |
| bus_valid | output | 1 | Register-bus request valid |
| bus_ready | input | 1 | Register-bus slave accepts the request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 24 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_last | output | 1 | Final beat of a command or of a fill chunk |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky unknown-opcode flag |

## Verification
A wrong index or a mis-evaluated condition shows on the bus at once as a transaction with the wrong address, or as a missing or extra one, because every command of the table leaves a distinct trace. A wrong beat or chunk counter shows within the same command as a shifted address, a misplaced `bus_last` or swapped pattern halves. Lost back-pressure state shows in the very next cycle as a request that changed or vanished while `bus_ready` was low. A run that stops too early or goes on too long shows at `done` as leftover or surplus transactions, and the error flag is compared at every end of run.

// File: rtl/initseq_pkg.sv
`timescale 1ns/1ps
package initseq_pkg;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 24;
  localparam int OPND_W = 32;
  localparam int HALF_W = OPND_W / 2;
  localparam int CMD_W  = OP_W + ADDR_W + OPND_W;

  // opcode values; everything above OP_IF_ANY is illegal
  typedef enum logic [OP_W-1:0] {
    OP_RD     = 4'd0,
    OP_WR     = 4'd1,
    OP_BURST  = 4'd2,
    OP_ZFILL  = 4'd3,
    OP_FILL64 = 4'd4,
    OP_IF_ALL = 4'd5,
    OP_IF_ANY = 4'd6
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [HALF_W-1:0] hi;   // length or mask
    logic [HALF_W-1:0] lo;   // offset, skip or immediate low half
  } cmd_t;
endpackage

// File: rtl/initseq_cond.sv
`timescale 1ns/1ps
module initseq_cond #(
  parameter int W = 16
) (
  input  logic         any_mode,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  output logic         skip
);
  logic [W-1:0] hit;

  assign hit = flags & mask;

  // all-of test skips on any missing bit, any-of test skips on no bit
  always_comb begin
    if (any_mode) skip = (hit == '0);
    else          skip = (hit != mask);
  end
endmodule

// File: rtl/initseq_beat.sv
`timescale 1ns/1ps
module initseq_beat #(
  parameter int CNT_W = 17,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic             chunked,
  input  logic             step,
  output logic [CNT_W-1:0] k,
  output logic             final_beat,
  output logic             chunk_end
);
  localparam int CH_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [CH_W-1:0] CH_TOP = CH_W'(CHUNK - 1);

  logic [CNT_W-1:0] k_q, tot_q;
  logic [CH_W-1:0]  c_q;
  logic             chunked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q       <= '0;
      tot_q     <= '0;
      c_q       <= '0;
      chunked_q <= 1'b0;
    end else if (load) begin
      k_q       <= '0;
      tot_q     <= total;
      c_q       <= '0;
      chunked_q <= chunked;
    end else if (step) begin
      k_q <= k_q + CNT_W'(1);
      c_q <= chunk_end ? '0 : c_q + CH_W'(1);
    end
  end

  assign k          = k_q;
  assign final_beat = (k_q == tot_q - CNT_W'(1));
  assign chunk_end  = final_beat || (chunked_q && (c_q == CH_TOP));

  // R5
  beat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (k_q < tot_q));
endmodule

// File: rtl/initseq_busreg.sv
`timescale 1ns/1ps
module initseq_busreg #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_write,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          ready,
  output logic          valid,
  output logic          write,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          last,
  output logic          taken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      write <= 1'b0;
      addr  <= '0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      write <= in_write;
      addr  <= in_addr;
      data  <= in_data;
      last  <= in_last;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign taken = valid && ready;

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data)
                           && $stable(write) && $stable(last)));

  // R11
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);
endmodule

// File: rtl/initseq_top.sv
`timescale 1ns/1ps
module initseq_top
  import initseq_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int DAT_AW      = 10,
  parameter int CHUNK_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [HALF_W-1:0] mode_flags,
  output logic [IDX_W-1:0]  cmd_raddr,
  input  logic [CMD_W-1:0]  cmd_rdata,
  output logic [DAT_AW-1:0] dat_raddr,
  input  logic [OPND_W-1:0] dat_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [OPND_W-1:0] bus_wdata,
  output logic              bus_last,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = HALF_W + 1;
  localparam int SUM_W = ((IDX_W > HALF_W) ? IDX_W : HALF_W) + 2;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_PAT_LO, S_PAT_HI, S_PAT_CAP,
    S_PREP, S_LOAD, S_WAIT, S_DONE
  } st_e;

  st_e               st_q, st_d;
  logic [IDX_W-1:0]  idx_q, end_q;
  logic              err_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OPND_W-1:0] imm_q;
  logic [OPND_W-1:0] lo_q, hi_q;

  cmd_t cmd_w;
  assign cmd_w = cmd_t'(cmd_rdata);

  // ---------------- condition and index arithmetic ----------------
  logic is_cond, cd_skip;
  assign is_cond = (cmd_w.op == OP_IF_ALL) || (cmd_w.op == OP_IF_ANY);

  initseq_cond #(.W(HALF_W)) u_cond (
    .any_mode (cmd_w.op == OP_IF_ANY),
    .flags    (mode_flags),
    .mask     (cmd_w.hi),
    .skip     (cd_skip)
  );

  logic [SUM_W-1:0] nxt_plain, adv_sum;
  logic             adv_end;
  always_comb begin
    nxt_plain = SUM_W'(idx_q) + SUM_W'(1);
    adv_sum   = nxt_plain;
    if (st_q == S_DECODE && is_cond && cd_skip)
      adv_sum = nxt_plain + SUM_W'(cmd_w.lo);
    adv_end = (adv_sum >= SUM_W'(end_q));
  end

  // ---------------- beat counter ----------------
  logic             bt_load, bt_chunked, bt_final, bt_chunk_end, bt_step;
  logic [CNT_W-1:0] bt_total, bt_k;

  always_comb begin
    case (cmd_w.op)
      OP_BURST, OP_ZFILL: bt_total = {1'b0, cmd_w.hi};
      OP_FILL64:          bt_total = {cmd_w.hi, 1'b0};
      default:            bt_total = CNT_W'(1);
    endcase
  end
  assign bt_chunked = (cmd_w.op == OP_ZFILL) || (cmd_w.op == OP_FILL64);
  assign bt_load    = (st_q == S_DECODE);

  initseq_beat #(.CNT_W(CNT_W), .CHUNK(CHUNK_WORDS)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (bt_load),
    .total      (bt_total),
    .chunked    (bt_chunked),
    .step       (bt_step),
    .k          (bt_k),
    .final_beat (bt_final),
    .chunk_end  (bt_chunk_end)
  );

  // ---------------- bus output stage ----------------
  logic              br_load, br_taken;
  logic [OPND_W-1:0] beat_data;
  logic [ADDR_W-1:0] beat_addr;

  always_comb begin
    case (op_q)
      OP_WR:     beat_data = imm_q;
      OP_BURST:  beat_data = dat_rdata;
      OP_FILL64: beat_data = bt_k[0] ? hi_q : lo_q;
      default:   beat_data = '0;
    endcase
  end
  assign beat_addr = addr_q + ADDR_W'({bt_k, 2'b00});
  assign br_load   = (st_q == S_LOAD);
  assign bt_step   = br_taken;

  initseq_busreg #(.AW(ADDR_W), .DW(OPND_W)) u_busreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (br_load),
    .in_write (op_q != OP_RD),
    .in_addr  (beat_addr),
    .in_data  (beat_data),
    .in_last  (bt_chunk_end),
    .ready    (bus_ready),
    .valid    (bus_valid),
    .write    (bus_write),
    .addr     (bus_addr),
    .data     (bus_wdata),
    .last     (bus_last),
    .taken    (br_taken)
  );

  // ---------------- memory addressing ----------------
  logic [CNT_W:0] dsum;
  always_comb begin
    case (st_q)
      S_PAT_LO: dsum = {2'b00, imm_q[HALF_W-1:0]};
      S_PAT_HI: dsum = {2'b00, imm_q[HALF_W-1:0]} + (CNT_W+1)'(1);
      default:  dsum = {2'b00, imm_q[HALF_W-1:0]} + {1'b0, bt_k};
    endcase
  end
  assign dat_raddr = DAT_AW'(dsum);
  assign cmd_raddr = idx_q;

  // ---------------- sequencing ----------------
  logic do_adv, do_err;

  always_comb begin
    st_d   = st_q;
    do_adv = 1'b0;
    do_err = 1'b0;
    case (st_q)
      S_IDLE:   if (start) st_d = (first_idx >= last_idx) ? S_DONE : S_FETCH;
      S_FETCH:  st_d = S_DECODE;
      S_DECODE: begin
        case (cmd_w.op)
          OP_RD, OP_WR:        st_d = S_LOAD;
          OP_BURST:            if (cmd_w.hi == '0) do_adv = 1'b1; else st_d = S_PREP;
          OP_ZFILL:            if (cmd_w.hi == '0) do_adv = 1'b1; else st_d = S_LOAD;
          OP_FILL64:           if (cmd_w.hi == '0) do_adv = 1'b1; else st_d = S_PAT_LO;
          OP_IF_ALL, OP_IF_ANY: do_adv = 1'b1;
          default: begin
            do_err = 1'b1;
            st_d   = S_DONE;
          end
        endcase
      end
      S_PAT_LO:  st_d = S_PAT_HI;
      S_PAT_HI:  st_d = S_PAT_CAP;
      S_PAT_CAP: st_d = S_LOAD;
      S_PREP:    st_d = S_LOAD;
      S_LOAD:    st_d = S_WAIT;
      S_WAIT: begin
        if (br_taken) begin
          if (bt_final)              do_adv = 1'b1;
          else if (op_q == OP_BURST) st_d = S_PREP;
          else                       st_d = S_LOAD;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (do_adv) st_d = adv_end ? S_DONE : S_FETCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      end_q  <= '0;
      err_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      imm_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && start) begin
        idx_q <= first_idx;
        end_q <= last_idx;
        err_q <= 1'b0;
      end
      if (do_adv) idx_q <= IDX_W'(adv_sum);
      if (do_err) err_q <= 1'b1;
      if (st_q == S_DECODE) begin
        op_q   <= cmd_w.op;
        addr_q <= cmd_w.addr;
        imm_q  <= {cmd_w.hi, cmd_w.lo};
      end
      if (st_q == S_PAT_HI)  lo_q <= dat_rdata;
      if (st_q == S_PAT_CAP) hi_q <= dat_rdata;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign done = (st_q == S_DONE);
  assign err  = err_q;

  // R1
  empty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && start && first_idx == last_idx) |=> done);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(st_q == S_IDLE && start)) |=> err);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_valid);

  // R2
  fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FETCH) |-> (idx_q < end_q));
endmodule

// File: tb/initseq_top_tb.sv
`timescale 1ns/1ps
module initseq_top_tb;
  import initseq_pkg::*;

  localparam int IDX_W  = 8;
  localparam int DAT_AW = 10;
  localparam int CHUNK  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  first_idx = '0, last_idx = '0;
  logic [15:0]       mode_flags = '0;
  logic [IDX_W-1:0]  cmd_raddr;
  logic [CMD_W-1:0]  cmd_rdata;
  logic [DAT_AW-1:0] dat_raddr;
  logic [31:0]       dat_rdata;
  logic              bus_valid, bus_ready, bus_write, bus_last, busy, done, err;
  logic [23:0]       bus_addr;
  logic [31:0]       bus_wdata;

  initseq_top #(.IDX_W(IDX_W), .DAT_AW(DAT_AW), .CHUNK_WORDS(CHUNK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx),
    .last_idx(last_idx), .mode_flags(mode_flags), .cmd_raddr(cmd_raddr),
    .cmd_rdata(cmd_rdata), .dat_raddr(dat_raddr), .dat_rdata(dat_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_last(bus_last),
    .busy(busy), .done(done), .err(err)
  );

  logic [CMD_W-1:0] cmem [0:255];
  logic [31:0]      dmem [0:1023];
  always @(posedge clk) begin
    cmd_rdata <= cmem[cmd_raddr];
    dat_rdata <= dmem[dat_raddr];
  end

  int checks = 0;
  int errors = 0;
  logic [57:0] exp_q[$];
  string       tag_q[$];
  bit          exp_err;
  string       cur_tag = "R2";
  bit          bp_en = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [CMD_W-1:0] mk(logic [3:0] op, logic [23:0] a,
                                          logic [15:0] h, logic [15:0] l);
    return {op, a, h, l};
  endfunction

  function automatic void push(bit wr, logic [31:0] a, logic [31:0] d, bit l, string t);
    exp_q.push_back({wr, l, a[23:0], d});
    tag_q.push_back(t);
  endfunction

  // behavioural reference: walk the table and list the expected accesses
  task automatic build(int first, int last, logic [15:0] flags);
    int i, op, h, l;
    logic [CMD_W-1:0] c;
    logic [31:0] a;
    exp_err = 1'b0;
    i = first;
    while (i < last) begin
      c  = cmem[i];
      op = int'(c[59:56]);
      a  = {8'd0, c[55:32]};
      h  = int'(c[31:16]);
      l  = int'(c[15:0]);
      if (op == 0) push(1'b0, a, 32'd0, 1'b1, "R3");
      else if (op == 1) push(1'b1, a, c[31:0], 1'b1, "R4");
      else if (op == 2) begin
        for (int w = 0; w < h; w++)
          push(1'b1, a + 32'(4*w), dmem[(l+w)%1024], (w == h-1), "R5");
      end else if (op == 3) begin
        for (int w = 0; w < h; w++)
          push(1'b1, a + 32'(4*w), 32'd0, ((w % CHUNK) == CHUNK-1) || (w == h-1), "R6");
      end else if (op == 4) begin
        for (int w = 0; w < 2*h; w++)
          push(1'b1, a + 32'(4*w), (w % 2 == 1) ? dmem[(l+1)%1024] : dmem[l%1024],
               ((w % CHUNK) == CHUNK-1) || (w == 2*h-1), "R7");
      end else if (op == 5) begin
        if ((flags & c[31:16]) != c[31:16]) i += l;
      end else if (op == 6) begin
        if ((flags & c[31:16]) == 16'd0) i += l;
      end else begin
        exp_err = 1'b1;
        break;
      end
      i++;
    end
  endtask

  // ready driver and per-clock bus comparison
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_hold = 1'b0;
  logic [57:0] prev_f = '0;
  always @(negedge clk) begin
    logic [57:0] e;
    string t;
    if (rst_n && prev_hold) begin
      checks++;
      if (!bus_valid || {bus_write, bus_last, bus_addr, bus_wdata} != prev_f) begin
        errors++;
        $display("FAIL R11 held request changed: actual v=%0b %h expected v=1 %h",
                 bus_valid, {bus_write, bus_last, bus_addr, bus_wdata}, prev_f);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_ready = bp_en ? (lfsr[1:0] != 2'b00) : 1'b1;
    if (rst_n && bus_valid && bus_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected access: actual addr=%h w=%0b expected none",
                 cur_tag, bus_addr, bus_write);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_write !== e[57] || bus_last !== e[56] || bus_addr !== e[55:32] ||
            (e[57] && bus_wdata !== e[31:0])) begin
          errors++;
          $display("FAIL %s actual w=%0b last=%0b addr=%h data=%h expected w=%0b last=%0b addr=%h data=%h",
                   t, bus_write, bus_last, bus_addr, bus_wdata, e[57], e[56], e[55:32], e[31:0]);
        end
      end
    end
    prev_hold = rst_n && bus_valid && !bus_ready;
    prev_f    = {bus_write, bus_last, bus_addr, bus_wdata};
  end

  task automatic run(int first, int last, logic [15:0] flags, bit bp, string tag);
    int n;
    build(first, last, flags);
    cur_tag = tag;
    bp_en   = bp;
    @(negedge clk);
    first_idx  = IDX_W'(first);
    last_idx   = IDX_W'(last);
    mode_flags = flags;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12", "busy after start", longint'(busy), 1);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R12", "done pulse seen", longint'(done), 1);
    if (first == last) chk(n == 0, "R1", "cycles until done", longint'(n), 0);
    chk(exp_q.size() == 0, "R2", "expected accesses left over", longint'(exp_q.size()), 0);
    chk(err == exp_err, "R10", "error flag at end", longint'(err), longint'(exp_err));
    @(negedge clk);
    chk(!done && !busy, "R12", "idle after done", longint'({done, busy}), 0);
    if (exp_err) chk(err == 1'b1, "R10", "error flag sticky", longint'(err), 1);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) cmem[i] = '0;
    for (int i = 0; i < 1024; i++) dmem[i] = 32'hA500_0000 + 32'(i * 257);
    // main program
    cmem[0]  = mk(4'd1, 24'h000100, 16'hDEAD, 16'hBEEF);
    cmem[1]  = mk(4'd0, 24'h000200, 16'h0000, 16'h0000);
    cmem[2]  = mk(4'd2, 24'h001000, 16'd3,    16'd10);
    cmem[3]  = mk(4'd3, 24'h002000, 16'd19,   16'd0);
    cmem[4]  = mk(4'd4, 24'h003000, 16'd5,    16'd20);
    cmem[5]  = mk(4'd5, 24'h000000, 16'h0005, 16'd1);
    cmem[6]  = mk(4'd1, 24'h000104, 16'h1111, 16'h2222);
    cmem[7]  = mk(4'd5, 24'h000000, 16'h0009, 16'd2);
    cmem[8]  = mk(4'd1, 24'h000108, 16'hBAD0, 16'h0008);
    cmem[9]  = mk(4'd1, 24'h00010C, 16'hBAD0, 16'h0009);
    cmem[10] = mk(4'd6, 24'h000000, 16'h0030, 16'd1);
    cmem[11] = mk(4'd1, 24'h000110, 16'hBAD0, 16'h0011);
    cmem[12] = mk(4'd6, 24'h000000, 16'h0002, 16'd1);
    cmem[13] = mk(4'd1, 24'h000114, 16'h3333, 16'h4444);
    cmem[14] = mk(4'd2, 24'h004000, 16'd0,    16'd0);
    cmem[15] = mk(4'd3, 24'h005000, 16'd8,    16'd0);
    cmem[16] = mk(4'd1, 24'h000118, 16'h5555, 16'h6666);
    // illegal opcode program
    cmem[20] = mk(4'd1, 24'h000700, 16'h0000, 16'h0001);
    cmem[21] = mk(4'hF, 24'h000000, 16'h0000, 16'h0000);
    cmem[22] = mk(4'd1, 24'h000704, 16'h0000, 16'h0002);
    // skip past the end of the range
    cmem[30] = mk(4'd6, 24'h000000, 16'h0001, 16'h3000);
    cmem[31] = mk(4'd1, 24'h000800, 16'hBAD0, 16'h0031);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy, "R12", "reset done/busy", longint'({done, busy}), 0);
    chk(!bus_valid, "R11", "reset bus_valid", longint'(bus_valid), 0);
    chk(!err, "R10", "reset err", longint'(err), 0);

    run(0, 17, 16'h0007, 1'b0, "R8");   // full table, no back-pressure
    run(0, 17, 16'h0007, 1'b1, "R11");  // same with back-pressure
    run(5, 5, 16'h0007, 1'b1, "R1");    // empty range
    run(13, 15, 16'h0007, 1'b1, "R2");  // sub-range, zero-length burst
    run(5, 17, 16'h0039, 1'b1, "R9");   // other mode flags
    run(20, 23, 16'h0000, 1'b1, "R10"); // unknown opcode aborts
    run(22, 23, 16'h0000, 1'b0, "R10"); // next start clears err
    run(30, 33, 16'h0000, 1'b1, "R9");  // jump beyond end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule